// File: doc/BRIEF.md
# Standby Mode and Clock-Gating Controller

This block is the power-management unit of a small microcontroller. The CPU raises a one-cycle stop strobe or wait strobe when it runs the matching low-power instruction. The block then drops the clock enables for the CPU core, the bus interface and the divided peripheral clock tree. It also drives the oscillator enable and a refresh-timing enable. A pending interrupt ends either low-power state. Leaving stop mode can be held until an external stabilisation handshake reports that the clock is good.

Two byte-wide registers sit on a simple write/read bus.

The configuration register:
- is protected by a key: a write of 0x55 only arms it, and the next write to it updates the bits;
- selects whether the stop strobe is honoured;
- selects whether the clock comes from an external source. An external clock needs no watchdog-timed restart.

The status register:
- holds the wait-mode clock-stop option;
- holds two sticky flags that record which low-power instruction ran. Only a power-on reset clears these flags; a warm reset leaves them as they were.

Top module: `standby_ctl`

## Requirements
- R1: With the configuration register (address 0x10) locked, a write of 0x55 to it changes no bit and arms it. The next write to that address loads bit 0 (external clock select) and bit 1 (stop disable), and locks it again. A write to that address while it is locked changes nothing.
- R2: The armed state is dropped by a write to any other address and by any reset, so a later data write to the configuration register is ignored.
- R3: With stop disable = 1, a stop strobe is ignored: all clock enables stay high and the stop flag (status bit 0) stays 0.
- R4: An accepted stop strobe makes the CPU, bus, peripheral, oscillator and refresh enables all 0 from the next cycle, and sets the stop flag.
- R5: With external clock select = 0, an interrupt in stop mode sets the oscillator enable and the watchdog-use output to 1 while the clocks stay off. The clocks stay off until stabilisation done is sampled high, and return the cycle after.
- R6: With external clock select = 1, an interrupt in stop mode restarts all clocks the next cycle, whatever stabilisation done is. The watchdog-use output stays 0.
- R7: A wait strobe with the clock-stop option (status bit 2) at 0 turns off the CPU and bus enables only. The peripheral, oscillator and refresh enables stay 1, and the wait flag (status bit 1) is set.
- R8: A wait strobe with the clock-stop option at 1 turns off the CPU, bus and peripheral enables. The oscillator and refresh enables stay 1.
- R9: An interrupt in wait mode restores all clock enables on the next cycle.
- R10: The stop and wait flags ignore software writes and keep their value through a warm reset. Only a power-on reset clears them.
- R11: Unused register bits read as 0, as does any other address. The configuration bits and the clock-stop option return to 0 on any reset, and all enables are 1 out of reset.
- R12: When stop and wait strobes arrive in the same cycle and stop is allowed, stop mode is entered and only the stop flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| warmRstN | input | 1 | Hardware or software reset, active low, asynchronous |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address for write and read |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| stopReq | input | 1 | Stop instruction strobe |
| waitReq | input | 1 | Wait instruction strobe |
| irqPending | input | 1 | Accepted interrupt request |
| stabDone | input | 1 | Clock stabilisation finished |
| cpuClkEn | output | 1 | CPU core clock enable |
| busClkEn | output | 1 | Bus-interface clock enable |
| perClkEn | output | 1 | Divided peripheral clock enable |
| oscEn | output | 1 | Oscillator enable |
| refreshEn | output | 1 | Refresh timing enable |
| wdtUseOnExit | output | 1 | Watchdog times the restart from stop |

## Verification
A register write is visible on the read port just after the edge that takes it, since reads decode the address without a register. A stop strobe, a wait strobe, an interrupt or a stabilisation handshake is taken at one edge, and the new enable pattern is decoded from the state register straight after that edge. The bench therefore drives every input two time units after a rising edge, waits one edge, and samples all enables two time units after that edge. Holding periods in the stabilisation phase are checked at each edge before the handshake rises.

// File: rtl/standby_ctl_pkg.sv
package standby_ctl_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_STOP = 2'd2,
    ST_STAB = 2'd3
  } pwrState_t;

  // register bit positions
  localparam int CFG_EXT_BIT   = 0;
  localparam int CFG_NOSTP_BIT = 1;
  localparam int ST_STOP_BIT   = 0;
  localparam int ST_WAIT_BIT   = 1;
  localparam int ST_GATE_BIT   = 2;

  // control -> datapath strobes
  typedef struct packed {
    logic setStopSeen;
    logic setWaitSeen;
  } ctlStrobe_t;

  // datapath -> control configuration view
  typedef struct packed {
    logic extClkSel;
    logic stopDisable;
    logic waitClkStop;
  } cfgView_t;

endpackage

// File: rtl/standby_ctl_regs.sv
module standby_ctl_regs
  import standby_ctl_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  CFG_ADDR  = 8'h10,
  parameter logic [7:0]  STAT_ADDR = 8'h11,
  parameter logic [7:0]  KEY       = 8'h55
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              anyRstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  ctlStrobe_t        strobe,
  output cfgView_t          cfg,
  output logic              stopSeenQ
);

  localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
  localparam logic [DATA_W-1:0] KEY_V  = DATA_W'(KEY);

  logic wrCfg, wrStat;
  logic armed;
  logic extClkQ, stopDisQ, gateQ;
  logic waitSeenQ;

  assign wrCfg  = regWrEn && (regAddr == CFG_A);
  assign wrStat = regWrEn && (regAddr == STAT_A);

  // key-protected configuration and clock-stop option: cleared by any reset
  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN) begin
      armed    <= 1'b0;
      extClkQ  <= 1'b0;
      stopDisQ <= 1'b0;
      gateQ    <= 1'b0;
    end else begin
      if (wrCfg) begin
        if (armed) begin
          extClkQ  <= regWrData[CFG_EXT_BIT];
          stopDisQ <= regWrData[CFG_NOSTP_BIT];
          armed    <= 1'b0;
        end else if (regWrData == KEY_V) begin
          armed <= 1'b1;
        end
      end else if (regWrEn) begin
        armed <= 1'b0;
      end
      if (wrStat) gateQ <= regWrData[ST_GATE_BIT];
    end
  end

  // sticky instruction flags: cleared by power-on reset only
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      stopSeenQ <= 1'b0;
      waitSeenQ <= 1'b0;
    end else begin
      if (strobe.setStopSeen) stopSeenQ <= 1'b1;
      if (strobe.setWaitSeen) waitSeenQ <= 1'b1;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == CFG_A) begin
      regRdData[CFG_EXT_BIT]   = extClkQ;
      regRdData[CFG_NOSTP_BIT] = stopDisQ;
    end else if (regAddr == STAT_A) begin
      regRdData[ST_STOP_BIT] = stopSeenQ;
      regRdData[ST_WAIT_BIT] = waitSeenQ;
      regRdData[ST_GATE_BIT] = gateQ;
    end
  end

  assign cfg.extClkSel   = extClkQ;
  assign cfg.stopDisable = stopDisQ;
  assign cfg.waitClkStop = gateQ;

endmodule

// File: rtl/standby_ctl_fsm.sv
module standby_ctl_fsm
  import standby_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       anyRstN,
  input  logic       stopReq,
  input  logic       waitReq,
  input  logic       irqPending,
  input  logic       stabDone,
  input  cfgView_t   cfg,
  output ctlStrobe_t strobe,
  output logic       cpuClkEn,
  output logic       busClkEn,
  output logic       perClkEn,
  output logic       oscEn,
  output logic       refreshEn,
  output logic       wdtUseOnExit
);

  pwrState_t state, stateNext;
  logic goStop, goWait;

  assign goStop = (state == ST_RUN) && stopReq && !cfg.stopDisable;
  assign goWait = (state == ST_RUN) && waitReq && !goStop;

  always_comb begin
    stateNext = state;
    case (state)
      ST_RUN:  if (goStop) stateNext = ST_STOP;
               else if (goWait) stateNext = ST_WAIT;
      ST_WAIT: if (irqPending) stateNext = ST_RUN;
      ST_STOP: if (irqPending) stateNext = cfg.extClkSel ? ST_RUN : ST_STAB;
      ST_STAB: if (stabDone) stateNext = ST_RUN;
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN) state <= ST_RUN;
    else          state <= stateNext;
  end

  assign strobe.setStopSeen = goStop;
  assign strobe.setWaitSeen = goWait;

  assign cpuClkEn     = (state == ST_RUN);
  assign busClkEn     = (state == ST_RUN);
  assign perClkEn     = (state == ST_RUN) || ((state == ST_WAIT) && !cfg.waitClkStop);
  assign oscEn        = (state != ST_STOP);
  assign refreshEn    = (state == ST_RUN) || (state == ST_WAIT);
  assign wdtUseOnExit = ((state == ST_STOP) || (state == ST_STAB)) && !cfg.extClkSel;

endmodule

// File: rtl/standby_ctl.sv
module standby_ctl
  import standby_ctl_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter int         DATA_W    = 8,
  parameter logic [7:0] CFG_ADDR  = 8'h10,
  parameter logic [7:0] STAT_ADDR = 8'h11,
  parameter logic [7:0] KEY       = 8'h55
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              warmRstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              stopReq,
  input  logic              waitReq,
  input  logic              irqPending,
  input  logic              stabDone,
  output logic              cpuClkEn,
  output logic              busClkEn,
  output logic              perClkEn,
  output logic              oscEn,
  output logic              refreshEn,
  output logic              wdtUseOnExit
);

  logic       anyRstN;
  ctlStrobe_t strobe;
  cfgView_t   cfg;
  logic       stopSeenQ;

  assign anyRstN = porRstN & warmRstN;

  standby_ctl_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CFG_ADDR(CFG_ADDR), .STAT_ADDR(STAT_ADDR), .KEY(KEY)
  ) uRegs (
    .clk(clk), .porRstN(porRstN), .anyRstN(anyRstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .strobe(strobe), .cfg(cfg),
    .stopSeenQ(stopSeenQ)
  );

  standby_ctl_fsm uFsm (
    .clk(clk), .anyRstN(anyRstN),
    .stopReq(stopReq), .waitReq(waitReq),
    .irqPending(irqPending), .stabDone(stabDone),
    .cfg(cfg), .strobe(strobe),
    .cpuClkEn(cpuClkEn), .busClkEn(busClkEn), .perClkEn(perClkEn),
    .oscEn(oscEn), .refreshEn(refreshEn), .wdtUseOnExit(wdtUseOnExit)
  );

endmodule

// File: rtl/standby_ctl_chk.sv
module standby_ctl_chk (
  input logic clk,
  input logic porRstN,
  input logic warmRstN,
  input logic stopReq,
  input logic waitReq,
  input logic irqPending,
  input logic stabDone,
  input logic cpuClkEn,
  input logic oscEn,
  input logic refreshEn,
  input logic wdtUseOnExit,
  input logic stopDisable,
  input logic extClkSel,
  input logic stopSeen
);

  AST_STOP_LOCKOUT: assert property (@(posedge clk) disable iff (!porRstN || !warmRstN)
    (cpuClkEn && stopReq && stopDisable && !waitReq) |=> cpuClkEn); // R3

  AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!porRstN || !warmRstN)
    (cpuClkEn && stopReq && !stopDisable) |=> (!oscEn && !refreshEn && !cpuClkEn && stopSeen)); // R4

  AST_STAB_START: assert property (@(posedge clk) disable iff (!porRstN || !warmRstN)
    (!oscEn && irqPending && !extClkSel) |=> (oscEn && !cpuClkEn && wdtUseOnExit)); // R5

  AST_STAB_HOLD: assert property (@(posedge clk) disable iff (!porRstN || !warmRstN)
    (oscEn && !refreshEn && !stabDone) |=> !cpuClkEn); // R5

  AST_EXT_EXIT: assert property (@(posedge clk) disable iff (!porRstN || !warmRstN)
    (!oscEn && irqPending && extClkSel) |=> cpuClkEn); // R6

  AST_WAIT_EXIT: assert property (@(posedge clk) disable iff (!porRstN || !warmRstN)
    (refreshEn && !cpuClkEn && irqPending) |=> cpuClkEn); // R9

  AST_WAIT_OSC: assert property (@(posedge clk) disable iff (!porRstN || !warmRstN)
    refreshEn |-> oscEn); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!porRstN)
    stopSeen |=> stopSeen); // R10

endmodule

bind standby_ctl standby_ctl_chk uChk (
  .clk(clk), .porRstN(porRstN), .warmRstN(warmRstN),
  .stopReq(stopReq), .waitReq(waitReq),
  .irqPending(irqPending), .stabDone(stabDone),
  .cpuClkEn(cpuClkEn), .oscEn(oscEn), .refreshEn(refreshEn),
  .wdtUseOnExit(wdtUseOnExit),
  .stopDisable(cfg.stopDisable), .extClkSel(cfg.extClkSel),
  .stopSeen(stopSeenQ)
);

// File: tb/standby_ctl_test.sv
`timescale 1ns/1ps
module standby_ctl_test;

  localparam logic [7:0] CFG  = 8'h10;
  localparam logic [7:0] STAT = 8'h11;
  // {cpu, bus, per, osc, refresh, wdtUse}
  localparam logic [5:0] P_RUN  = 6'b111110;
  localparam logic [5:0] P_STAB = 6'b000101;

  logic clk = 1'b0;
  logic porRstN = 1'b0, warmRstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regAddr = 8'h00, regWrData = 8'h00;
  logic [7:0] regRdData;
  logic stopReq = 1'b0, waitReq = 1'b0, irqPending = 1'b0, stabDone = 1'b0;
  logic cpuClkEn, busClkEn, perClkEn, oscEn, refreshEn, wdtUseOnExit;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;  // 50 MHz

  standby_ctl uut (
    .clk(clk), .porRstN(porRstN), .warmRstN(warmRstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .stopReq(stopReq), .waitReq(waitReq),
    .irqPending(irqPending), .stabDone(stabDone),
    .cpuClkEn(cpuClkEn), .busClkEn(busClkEn), .perClkEn(perClkEn),
    .oscEn(oscEn), .refreshEn(refreshEn), .wdtUseOnExit(wdtUseOnExit)
  );

  function automatic logic [5:0] expStop(input logic ext);
    return {5'b00000, ~ext};
  endfunction

  function automatic logic [5:0] expWait(input logic gate);
    return gate ? 6'b000110 : 6'b001110;
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkPins(input string req, input logic [5:0] exp);
    check(req, {26'd0, cpuClkEn, busClkEn, perClkEn, oscEn, refreshEn, wdtUseOnExit},
          {26'd0, exp});
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic rdCheck(input string req, input logic [7:0] a, input logic [7:0] exp);
    regAddr = a;
    #1;
    check(req, {24'd0, regRdData}, {24'd0, exp});
  endtask

  task automatic setCfg(input logic [7:0] v);
    wr(CFG, 8'h55);
    wr(CFG, v);
  endtask

  task automatic pulse(input logic s, input logic w);
    stopReq = s; waitReq = w;
    tick();
    stopReq = 1'b0; waitReq = 1'b0;
  endtask

  task automatic irq();
    irqPending = 1'b1;
    tick();
    irqPending = 1'b0;
  endtask

  task automatic warmReset();
    warmRstN = 1'b0;
    tick();
    warmRstN = 1'b1;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    porRstN = 1'b1; warmRstN = 1'b1;
    tick();

    // R11 reset state
    checkPins("R11 reset pins", P_RUN);
    rdCheck("R11 reset cfg", CFG, 8'h00);
    rdCheck("R11 reset stat", STAT, 8'h00);
    wr(STAT, 8'hFF);
    rdCheck("R11 unused bits / R10 flags ignore write", STAT, 8'h04);
    wr(STAT, 8'h00);
    rdCheck("R11 other address", 8'h20, 8'h00);

    // R1 key sequence
    wr(CFG, 8'h55);
    rdCheck("R1 key alone", CFG, 8'h00);
    wr(CFG, 8'hFF);
    rdCheck("R1 unlocked write", CFG, 8'h03);
    wr(CFG, 8'h00);
    rdCheck("R1 locked write ignored", CFG, 8'h03);
    setCfg(8'h00);
    rdCheck("R1 relock write", CFG, 8'h00);

    // R2 arming lost
    wr(CFG, 8'h55);
    wr(STAT, 8'h00);
    wr(CFG, 8'h03);
    rdCheck("R2 other address disarms", CFG, 8'h00);
    wr(CFG, 8'h55);
    warmReset();
    wr(CFG, 8'h01);
    rdCheck("R2 reset disarms", CFG, 8'h00);

    // R3 stop disabled
    setCfg(8'h02);
    pulse(1'b1, 1'b0);
    checkPins("R3 stop ignored", P_RUN);
    rdCheck("R3 flag clear", STAT, 8'h00);
    setCfg(8'h00);

    // R12 / R4 simultaneous strobes, stop wins
    pulse(1'b1, 1'b1);
    checkPins("R4 R12 stop entry", expStop(1'b0));
    rdCheck("R12 only stop flag", STAT, 8'h01);

    // R5 watchdog-timed exit
    irq();
    checkPins("R5 stab phase", P_STAB);
    tick();
    tick();
    checkPins("R5 hold until stabDone", P_STAB);
    stabDone = 1'b1;
    tick();
    stabDone = 1'b0;
    checkPins("R5 resume", P_RUN);

    // R6 external clock exit
    setCfg(8'h01);
    pulse(1'b1, 1'b0);
    checkPins("R6 stop entry", expStop(1'b1));
    irq();
    checkPins("R6 immediate resume", P_RUN);
    setCfg(8'h00);

    // R7 / R9 wait, peripherals running
    pulse(1'b0, 1'b1);
    checkPins("R7 wait gate0", expWait(1'b0));
    rdCheck("R7 wait flag", STAT, 8'h03);
    tick();
    checkPins("R7 wait stays", expWait(1'b0));
    irq();
    checkPins("R9 wait exit", P_RUN);

    // R8 wait, all clocks gated
    wr(STAT, 8'h04);
    pulse(1'b0, 1'b1);
    checkPins("R8 wait gate1", expWait(1'b1));
    irq();
    checkPins("R9 wait exit gate1", P_RUN);
    wr(STAT, 8'h00);

    // R10 flag persistence
    rdCheck("R10 write zero ignored", STAT, 8'h03);
    wr(STAT, 8'h04);
    warmReset();
    rdCheck("R10 R11 warm reset keeps flags, clears gate", STAT, 8'h03);
    porRstN = 1'b0;
    tick();
    porRstN = 1'b1;
    tick();
    rdCheck("R10 power-on clears", STAT, 8'h00);

    // constrained random sequences
    for (int i = 0; i < 40; i++) begin
      logic ext, gate, doStop;
      int hold;
      ext = 1'($urandom % 2);
      gate = 1'($urandom % 2);
      doStop = 1'($urandom % 2);
      hold = int'($urandom % 4);
      setCfg({7'd0, ext});
      wr(STAT, {5'd0, gate, 2'b00});
      if (doStop) begin
        pulse(1'b1, 1'b0);
        checkPins("R4 random stop", expStop(ext));
        stabDone = 1'($urandom % 2);
        irq();
        stabDone = 1'b0;
        if (ext) begin
          checkPins("R6 random exit", P_RUN);
        end else begin
          checkPins("R5 random stab", P_STAB);
          for (int k = 0; k < hold; k++) begin
            tick();
            checkPins("R5 random hold", P_STAB);
          end
          stabDone = 1'b1;
          tick();
          stabDone = 1'b0;
          checkPins("R5 random resume", P_RUN);
        end
      end else begin
        pulse(1'b0, 1'b1);
        checkPins(gate ? "R8 random wait" : "R7 random wait", expWait(gate));
        for (int k = 0; k < hold; k++) tick();
        irq();
        checkPins("R9 random exit", P_RUN);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule